// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetcher

This block moves packets from a ring of transmit descriptors in word-organised memory to a byte stream. Each descriptor is two 32-bit words. The first word carries an ownership flag, a chaining flag and a byte count. The second word carries the address of a data buffer. Software fills descriptors, sets their ownership flags and pulses `kick`. The engine then checks that the whole chain of the next packet is handed over. After that it reads the buffers and streams the bytes out with start and end markers. When the packet is done it returns the descriptors to software and raises a one-cycle interrupt.

The engine works in two passes. The scan pass reads only the first word of each descriptor in the chain. It confirms ownership, sums the lengths and finds the end of the chain. The transfer pass reads each descriptor again, reads its buffer, emits the bytes and releases the descriptor. Because of this split, a chain that breaks in the middle is rejected before any byte leaves the block. The packet also needs no on-chip storage.

The ring is set by a base address and a length in descriptors. A maximum packet size caps the stream and sets an overflow status. The current ring pointer can be loaded while the engine is idle, and it is always visible as an output.

Top module: `txd_ring_fetch`

## Requirements
- R1: Descriptors lie at an 8-byte stride. Word 0 is at the pointer and word 1 is at pointer+4. Word 0 holds the ownership flag in bit 31, the chaining flag in bit 30 and the byte count in bits 15:0. Word 1 holds a word-aligned byte address of the buffer. The memory port addresses 32-bit words: the word address is the byte address shifted right by 2.
- R2: If `kick` arrives while word 0 at `cur_ptr` has bit 31 clear, the engine emits no bytes, does no memory write and raises no interrupt, and `cur_ptr` keeps its value.
- R3: While the chaining flag is set, the next descriptor belongs to the same packet. The stream carries the buffers in chain order. `tx_sop` marks the first byte and `tx_eop` marks the last byte.
- R4: If a descriptor later in the chain has bit 31 clear, the packet is dropped. No byte is emitted, nothing is written, no interrupt is raised and `cur_ptr` is unchanged. A chain longer than MAX_CHAIN descriptors is dropped in the same way.
- R5: A descriptor whose byte count is zero adds no bytes to the stream. It is still released and stepped past.
- R6: Each buffer word is sent most significant byte first, so bits 31:24 go out before bits 23:16. Only the declared byte count of a buffer is sent, and a partial last word is cut short.
- R7: Every descriptor after the first in a packet is released by a write of zero to its word 0.
- R8: After the last byte, word 0 of the first descriptor is written back with bit 31 cleared and all other bits as they were read. `irq` is high for exactly one cycle after that write.
- R9: The pointer steps by 8 for each descriptor and wraps to `cfg_ring_base` after `cfg_ring_len` descriptors. After a packet, `cur_ptr` points to the descriptor after the last one used.
- R10: A packet whose byte counts sum to zero produces no stream activity. It still releases all its descriptors and raises `irq`.
- R11: The stream is cut at `cfg_max_bytes` bytes, and `tx_eop` is on the last byte sent. `ovf` is set for a packet whose total exceeds the limit and cleared by an accepted packet that fits. The trailing descriptors are released either way.
- R12: A `ptr_load` pulse while idle copies `ptr_value` into `cur_ptr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ring_base | input | PTR_W | Byte address of the first ring slot |
| cfg_ring_len | input | RING_W | Number of descriptors in the ring |
| cfg_max_bytes | input | LEN_W | Largest packet size sent |
| ptr_load | input | 1 | Load `cur_ptr` from `ptr_value` while idle |
| ptr_value | input | PTR_W | Value for the pointer load |
| kick | input | 1 | Try to send the packet at `cur_ptr` |
| cur_ptr | output | PTR_W | Byte address of the next descriptor |
| busy | output | 1 | Engine is working on a kick |
| ovf | output | 1 | Last accepted packet was cut short |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | PTR_W-2 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_sop | output | 1 | First byte of a packet |
| tx_eop | output | 1 | Last byte of a packet |
| irq | output | 1 | One-cycle completion pulse |

## Verification
Several internal faults would show at the ports within the same packet:
- A wrong scan total or limit moves `tx_eop` or changes the byte count.
- A wrong lane counter mixes up the byte order within the first buffer word.
- A wrong pointer step shows in the write-back addresses and in `cur_ptr` when `busy` falls.

A fault in the first-word latch would only show in the final write-back value. For that reason memory contents are compared after every packet, dropped packets included.

// File: rtl/txd_pkg.sv
package txd_pkg;

    localparam int OWN_BIT  = 31;
    localparam int CONT_BIT = 30;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SCAN_REQ,
        ST_SCAN_WAIT,
        ST_W0_REQ,
        ST_W0_WAIT,
        ST_W1_REQ,
        ST_W1_WAIT,
        ST_BUF_CHK,
        ST_BUF_REQ,
        ST_BUF_WAIT,
        ST_EMIT,
        ST_REL,
        ST_FIN
    } fetch_state_t;

    function automatic logic desc_owned(input logic [31:0] w0);
        return w0[OWN_BIT];
    endfunction

    function automatic logic desc_chained(input logic [31:0] w0);
        return w0[CONT_BIT];
    endfunction

    function automatic logic [31:0] desc_release_first(input logic [31:0] w0);
        logic [31:0] r;
        r = w0;
        r[OWN_BIT] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/txd_ptr_step.sv
module txd_ptr_step #(
    parameter int PTR_W  = 16,
    parameter int RING_W = 8
) (
    input  logic [PTR_W-1:0]  ptr_in,
    input  logic [PTR_W-1:0]  ring_base,
    input  logic [RING_W-1:0] ring_len,
    output logic [PTR_W-1:0]  ptr_next
);
    localparam int STRIDE = 8;

    logic [PTR_W-1:0] ring_end;
    logic [PTR_W-1:0] stepped;

    always_comb begin
        ring_end = ring_base + (PTR_W'(ring_len) << 3);
        stepped  = ptr_in + PTR_W'(STRIDE);
        ptr_next = (stepped == ring_end) ? ring_base : stepped;
    end
endmodule

// File: rtl/txd_lane_pick.sv
module txd_lane_pick (
    input  logic [31:0] word_in,
    input  logic [1:0]  lane,
    output logic [7:0]  byte_out
);
    always_comb begin
        case (lane)
            2'd0:    byte_out = word_in[31:24];
            2'd1:    byte_out = word_in[23:16];
            2'd2:    byte_out = word_in[15:8];
            default: byte_out = word_in[7:0];
        endcase
    end
endmodule

// File: rtl/txd_ring_fetch.sv
module txd_ring_fetch
    import txd_pkg::*;
#(
    parameter int PTR_W     = 16,
    parameter int RING_W    = 8,
    parameter int LEN_W     = 16,
    parameter int MAX_CHAIN = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PTR_W-1:0]  cfg_ring_base,
    input  logic [RING_W-1:0] cfg_ring_len,
    input  logic [LEN_W-1:0]  cfg_max_bytes,
    input  logic              ptr_load,
    input  logic [PTR_W-1:0]  ptr_value,
    input  logic              kick,
    output logic [PTR_W-1:0]  cur_ptr,
    output logic              busy,
    output logic              ovf,
    output logic              mem_req,
    output logic              mem_we,
    output logic [PTR_W-3:0]  mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_sop,
    output logic              tx_eop,
    output logic              irq
);
    localparam int AW    = PTR_W - 2;
    localparam int CNT_W = $clog2(MAX_CHAIN + 1);
    localparam int TOT_W = LEN_W + CNT_W;

    fetch_state_t state;

    logic [PTR_W-1:0] cur_q, scan_ptr, walk_ptr;
    logic [31:0]      first_w0, word_q;
    logic [CNT_W-1:0] chain_cnt;
    logic [TOT_W-1:0] total, eff, sent;
    logic [LEN_W-1:0] d_len, consumed;
    logic             d_cont, is_first, ovf_q, irq_q;
    logic [AW-1:0]    buf_addr;
    logic [1:0]       lane;

    logic [PTR_W-1:0] step_in, step_out;
    logic [TOT_W-1:0] tot_new, max_ext;

    assign step_in = (state == ST_SCAN_WAIT) ? scan_ptr : walk_ptr;

    txd_ptr_step #(.PTR_W(PTR_W), .RING_W(RING_W)) u_step (
        .ptr_in   (step_in),
        .ring_base(cfg_ring_base),
        .ring_len (cfg_ring_len),
        .ptr_next (step_out)
    );

    txd_lane_pick u_lane (
        .word_in (word_q),
        .lane    (lane),
        .byte_out(tx_data)
    );

    assign tot_new = total + TOT_W'(mem_rdata[LEN_W-1:0]);
    assign max_ext = TOT_W'(cfg_max_bytes);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cur_q     <= '0;
            scan_ptr  <= '0;
            walk_ptr  <= '0;
            first_w0  <= '0;
            word_q    <= '0;
            chain_cnt <= '0;
            total     <= '0;
            eff       <= '0;
            sent      <= '0;
            d_len     <= '0;
            consumed  <= '0;
            d_cont    <= 1'b0;
            is_first  <= 1'b0;
            ovf_q     <= 1'b0;
            irq_q     <= 1'b0;
            buf_addr  <= '0;
            lane      <= '0;
        end else begin
            irq_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (ptr_load) begin
                        cur_q <= ptr_value;
                    end else if (kick) begin
                        scan_ptr  <= cur_q;
                        chain_cnt <= '0;
                        total     <= '0;
                        state     <= ST_SCAN_REQ;
                    end
                end
                ST_SCAN_REQ: state <= ST_SCAN_WAIT;
                ST_SCAN_WAIT: begin
                    if (mem_rvalid) begin
                        if (!desc_owned(mem_rdata)) begin
                            state <= ST_IDLE;
                        end else begin
                            if (chain_cnt == '0) first_w0 <= mem_rdata;
                            total     <= tot_new;
                            chain_cnt <= chain_cnt + 1'b1;
                            if (desc_chained(mem_rdata)) begin
                                if (chain_cnt == CNT_W'(MAX_CHAIN - 1)) begin
                                    state <= ST_IDLE;
                                end else begin
                                    scan_ptr <= step_out;
                                    state    <= ST_SCAN_REQ;
                                end
                            end else begin
                                ovf_q    <= (tot_new > max_ext);
                                eff      <= (tot_new > max_ext) ? max_ext : tot_new;
                                walk_ptr <= cur_q;
                                is_first <= 1'b1;
                                sent     <= '0;
                                state    <= ST_W0_REQ;
                            end
                        end
                    end
                end
                ST_W0_REQ: state <= ST_W0_WAIT;
                ST_W0_WAIT: begin
                    if (mem_rvalid) begin
                        d_len  <= mem_rdata[LEN_W-1:0];
                        d_cont <= desc_chained(mem_rdata);
                        state  <= ST_W1_REQ;
                    end
                end
                ST_W1_REQ: state <= ST_W1_WAIT;
                ST_W1_WAIT: begin
                    if (mem_rvalid) begin
                        buf_addr <= mem_rdata[PTR_W-1:2];
                        consumed <= '0;
                        state    <= ST_BUF_CHK;
                    end
                end
                ST_BUF_CHK: begin
                    if (consumed == d_len || sent >= eff) state <= ST_REL;
                    else                                  state <= ST_BUF_REQ;
                end
                ST_BUF_REQ: state <= ST_BUF_WAIT;
                ST_BUF_WAIT: begin
                    if (mem_rvalid) begin
                        word_q <= mem_rdata;
                        lane   <= '0;
                        state  <= ST_EMIT;
                    end
                end
                ST_EMIT: begin
                    sent     <= sent + 1'b1;
                    consumed <= consumed + 1'b1;
                    lane     <= lane + 1'b1;
                    if (sent + 1'b1 == eff) begin
                        state <= ST_REL;
                    end else if (consumed + 1'b1 == d_len) begin
                        state <= ST_REL;
                    end else if (lane == 2'd3) begin
                        buf_addr <= buf_addr + 1'b1;
                        state    <= ST_BUF_REQ;
                    end
                end
                ST_REL: begin
                    is_first <= 1'b0;
                    walk_ptr <= step_out;
                    state    <= d_cont ? ST_W0_REQ : ST_FIN;
                end
                ST_FIN: begin
                    cur_q <= walk_ptr;
                    irq_q <= 1'b1;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = walk_ptr[PTR_W-1:2];
        mem_wdata = '0;
        case (state)
            ST_SCAN_REQ: begin
                mem_req  = 1'b1;
                mem_addr = scan_ptr[PTR_W-1:2];
            end
            ST_W0_REQ: mem_req = 1'b1;
            ST_W1_REQ: begin
                mem_req  = 1'b1;
                mem_addr = walk_ptr[PTR_W-1:2] + AW'(1);
            end
            ST_BUF_REQ: begin
                mem_req  = 1'b1;
                mem_addr = buf_addr;
            end
            ST_REL: begin
                mem_req = !is_first;
                mem_we  = !is_first;
            end
            ST_FIN: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_q[PTR_W-1:2];
                mem_wdata = desc_release_first(first_w0);
            end
            default: ;
        endcase
    end

    assign tx_valid = (state == ST_EMIT);
    assign tx_sop   = tx_valid && (sent == '0);
    assign tx_eop   = tx_valid && (sent + 1'b1 == eff);
    assign cur_ptr  = cur_q;
    assign busy     = (state != ST_IDLE);
    assign ovf      = ovf_q;
    assign irq      = irq_q;

endmodule

module txd_ring_fetch_chk #(
    parameter int PTR_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             tx_valid,
    input logic             tx_sop,
    input logic             tx_eop,
    input logic             irq,
    input logic             ptr_load,
    input logic [PTR_W-1:0] cur_ptr,
    input logic             mem_req,
    input logic             mem_we,
    input logic             wb_own
);
    AST_MARKS_NEED_VALID: assert property (@(posedge clk) disable iff (rst)
        (tx_sop || tx_eop) |-> tx_valid);                              // R3
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);                                                 // R8
    AST_PTR_HELD: assert property (@(posedge clk) disable iff (rst)
        (!irq && !$past(ptr_load)) |-> $stable(cur_ptr));              // R2
    AST_WRITE_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> !wb_own);                              // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!tx_valid && !mem_req));                            // R4
endmodule

bind txd_ring_fetch txd_ring_fetch_chk #(.PTR_W(PTR_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .tx_valid(tx_valid),
    .tx_sop  (tx_sop),
    .tx_eop  (tx_eop),
    .irq     (irq),
    .ptr_load(ptr_load),
    .cur_ptr (cur_ptr),
    .mem_req (mem_req),
    .mem_we  (mem_we),
    .wb_own  (mem_wdata[31])
);

// File: tb/txd_ring_fetch_bench.sv
module txd_ring_fetch_bench;
    localparam int PTR_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [PTR_W-1:0] cfg_ring_base = 16'h0100;
    logic [7:0]       cfg_ring_len  = 8'd4;
    logic [15:0]      cfg_max_bytes = 16'd64;
    logic             ptr_load = 1'b0;
    logic [PTR_W-1:0] ptr_value = '0;
    logic             kick = 1'b0;
    logic [PTR_W-1:0] cur_ptr;
    logic busy, ovf, mem_req, mem_we, mem_rvalid, tx_valid, tx_sop, tx_eop, irq;
    logic [PTR_W-3:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic [7:0]  tx_data;

    always #5 clk = ~clk;

    txd_ring_fetch u_txd_ring_fetch (
        .clk(clk), .rst(rst), .cfg_ring_base(cfg_ring_base), .cfg_ring_len(cfg_ring_len),
        .cfg_max_bytes(cfg_max_bytes), .ptr_load(ptr_load), .ptr_value(ptr_value),
        .kick(kick), .cur_ptr(cur_ptr), .busy(busy), .ovf(ovf), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_sop(tx_sop), .tx_eop(tx_eop), .irq(irq)
    );

    logic [31:0] mem [0:1023];
    logic [7:0]  cap [0:255];
    logic        cap_sop [0:255];
    logic        cap_eop [0:255];
    int cap_n = 0;
    int irq_n = 0;
    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_req && mem_we) mem[mem_addr[9:0]] <= mem_wdata;
        if (mem_req && !mem_we) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= mem[mem_addr[9:0]];
        end
        if (tx_valid && cap_n < 256) begin
            cap[cap_n]     <= tx_data;
            cap_sop[cap_n] <= tx_sop;
            cap_eop[cap_n] <= tx_eop;
            cap_n          <= cap_n + 1;
        end
        if (irq) irq_n <= irq_n + 1;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_kick();
        @(negedge clk) kick = 1'b1;
        @(negedge clk) kick = 1'b0;
        for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_stream(input string tag, input int start, input int n,
                                input logic [63:0] bytes);
        check({tag, " byte count"}, cap_n - start, n);
        for (int i = 0; i < n; i++) begin
            check({tag, " data"}, cap[start+i], bytes[63-8*i -: 8]);
            check({tag, " sop"}, cap_sop[start+i], i == 0);
            check({tag, " eop"}, cap_eop[start+i], i == n - 1);
        end
    endtask

    task automatic t_reset();
        check("R12 reset cur_ptr", cur_ptr, 0);
        check("R12 reset busy", busy, 0);
        check("R11 reset ovf", ovf, 0);
        check("R8 reset irq", irq, 0);
        @(negedge clk) begin ptr_load = 1'b1; ptr_value = 16'h0100; end
        @(negedge clk) ptr_load = 1'b0;
        check("R12 pointer load", cur_ptr, 16'h0100);
    endtask

    task automatic t_single();
        int s0, i0;
        mem[10'h040] = 32'h8010_0006;  mem[10'h041] = 32'h0000_0200;
        mem[10'h080] = 32'h1122_3344;  mem[10'h081] = 32'h5566_7788;
        s0 = cap_n; i0 = irq_n;
        run_kick();
        check_stream("R1 R6 single", s0, 6, 64'h1122_3344_5566_0000);
        check("R8 first write-back", mem[10'h040], 32'h0010_0006);
        check("R8 irq count", irq_n - i0, 1);
        check("R9 pointer step", cur_ptr, 16'h0108);
    endtask

    task automatic t_not_owned();
        int s0, i0;
        mem[10'h042] = 32'h0000_0004;
        s0 = cap_n; i0 = irq_n;
        run_kick();
        check("R2 no bytes", cap_n - s0, 0);
        check("R2 no irq", irq_n - i0, 0);
        check("R2 pointer kept", cur_ptr, 16'h0108);
        check("R2 desc untouched", mem[10'h042], 32'h0000_0004);
    endtask

    task automatic t_chain_wrap();
        int s0, i0;
        mem[10'h042] = 32'hC000_0003;  mem[10'h043] = 32'h0000_0300;
        mem[10'h044] = 32'hC000_0000;  mem[10'h045] = 32'h0000_0320;
        mem[10'h046] = 32'h8000_0005;  mem[10'h047] = 32'h0000_0340;
        mem[10'h0C0] = 32'hA1A2_A3A4;
        mem[10'h0D0] = 32'hC1C2_C3C4;  mem[10'h0D1] = 32'hC5C6_C7C8;
        s0 = cap_n; i0 = irq_n;
        run_kick();
        check_stream("R3 R5 R6 chain", s0, 8, 64'hA1A2_A3C1_C2C3_C4C5);
        check("R8 chain first wb", mem[10'h042], 32'h4000_0003);
        check("R5 R7 zero-len released", mem[10'h044], 32'h0);
        check("R7 last released", mem[10'h046], 32'h0);
        check("R9 wrap to base", cur_ptr, 16'h0100);
        check("R8 chain irq", irq_n - i0, 1);
    endtask

    task automatic t_abort_then_empty();
        int s0, i0;
        mem[10'h040] = 32'hC000_0004;  mem[10'h041] = 32'h0000_0200;
        mem[10'h042] = 32'h4000_0000;
        s0 = cap_n; i0 = irq_n;
        run_kick();
        check("R4 abort no bytes", cap_n - s0, 0);
        check("R4 abort first kept", mem[10'h040], 32'hC000_0004);
        check("R4 abort pointer", cur_ptr, 16'h0100);
        check("R4 abort no irq", irq_n - i0, 0);
        mem[10'h040] = 32'hC000_0000;
        mem[10'h042] = 32'h8000_0000;  mem[10'h043] = 32'h0000_0200;
        s0 = cap_n; i0 = irq_n;
        run_kick();
        check("R10 empty no bytes", cap_n - s0, 0);
        check("R10 empty first wb", mem[10'h040], 32'h4000_0000);
        check("R10 empty trailing", mem[10'h042], 32'h0);
        check("R10 empty irq", irq_n - i0, 1);
        check("R9 empty pointer", cur_ptr, 16'h0110);
    endtask

    task automatic t_truncate();
        int s0, i0;
        cfg_max_bytes = 16'd5;
        mem[10'h044] = 32'hC000_0004;  mem[10'h045] = 32'h0000_0380;
        mem[10'h046] = 32'h8000_0004;  mem[10'h047] = 32'h0000_03A0;
        mem[10'h0E0] = 32'h0102_0304;  mem[10'h0E8] = 32'h0506_0708;
        s0 = cap_n; i0 = irq_n;
        run_kick();
        check_stream("R11 truncated", s0, 5, 64'h0102_0304_0500_0000);
        check("R11 ovf set", ovf, 1);
        check("R11 trailing released", mem[10'h046], 32'h0);
        check("R11 first wb", mem[10'h044], 32'h4000_0004);
        check("R11 irq", irq_n - i0, 1);
        cfg_max_bytes = 16'd64;
        mem[10'h040] = 32'h8000_0002;  mem[10'h041] = 32'h0000_0200;
        s0 = cap_n;
        run_kick();
        check_stream("R11 fits", s0, 2, 64'h1122_0000_0000_0000);
        check("R11 ovf cleared", ovf, 0);
        check("R9 pointer after fit", cur_ptr, 16'h0108);
    endtask

    task automatic t_load();
        @(negedge clk) begin ptr_load = 1'b1; ptr_value = 16'h0118; end
        @(negedge clk) ptr_load = 1'b0;
        check("R12 reload", cur_ptr, 16'h0118);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single();
        t_not_owned();
        t_chain_wrap();
        t_abort_then_empty();
        t_truncate();
        t_load();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule